// File: doc/BRIEF.md
# HDLC Serial Frame Transmitter

This block turns packets offered one byte at a time into a serial bit-oriented HDLC stream. Bytes arrive on a valid/ready interface that carries a last-byte marker. The line side moves one bit for every clock cycle in which the bit-enable input is high. This lets one design serve a slow data link that fires the enable only now and then, or a full time slot where the enable is high on every cycle.

While no packet is offered, the line carries back-to-back flags. A packet goes out as the data bytes with zero insertion, then a 16-bit frame check sequence, then a closing flag. The check sequence may be left out for a whole frame. A frame can be cut short in three ways: by an abort command, by the byte source running dry partway through the frame, or by a packet that is too short. Each of these sends an abort pattern, and idle flags follow it.

Back-pressure rules: `s_ready` is high only in a bit-enable cycle in which the transmitter needs its next byte, and it never depends on `s_valid`. A byte moves on a clock edge where `s_valid` and `s_ready` are both high. The source must hold `s_data`, `s_last` and `fcs_inhibit` stable while `s_valid` is high. Once a frame has been aborted, the source is expected to drop the unsent rest of that packet.

Top module: `hdlc_tx`

## Requirements
- R1: During reset and right after it, `tx_bit` is 1 and `s_ready`, `eop` and `underflow` are 0.
- R2: The flag 0x7E goes out least significant bit first (0,1,1,1,1,1,1,0). Flags follow one another with no gap while no frame is in progress, and at least one flag comes before the first data bit of every frame.
- R3: Data bytes go out least significant bit first, in the order they were accepted. A byte is accepted on a clock edge where `s_valid` and `s_ready` are both high.
- R4: Across the data field and the check sequence, a 0 is inserted after every run of five 1s, including a run that ends the check sequence or the data just before the closing flag.
- R5: Unless inhibited, the frame check sequence follows the last data byte. It is the reflected CRC-16 with polynomial 0x8408 (x^16+x^12+x^5+1), preset to 0xFFFF, sent ones-complemented with the low bit first. A receiver running the same CRC over the data and the check sequence ends with 0xF0B8.
- R6: `fcs_inhibit` is sampled together with the first byte of a frame. When it is 1, the closing flag follows the last data bit (after any inserted 0) with no check sequence.
- R7: A one-cycle `eop` pulse is raised in the cycle in which `tx_bit` first shows the last bit of a frame's closing flag. `eop` is never high in the same cycle as `underflow`.
- R8: If no byte is offered when the next data byte of an unfinished frame is due, `underflow` pulses for one cycle. The frame is then ended with the abort pattern, which is a 0 followed by seven 1s with no zero insertion. Flags follow the abort pattern.
- R9: A one-cycle `abort_req` during the data or check-sequence part of a frame starts the abort pattern on the next bit-enable cycle. At any other time it has no effect.
- R10: A packet whose first byte carries `s_last` is sent as an aborted frame. It produces neither `eop` nor `underflow`.
- R11: `tx_bit` changes only on clock edges where `bit_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Line bit enable: one serial bit per high cycle |
| s_data | input | 8 | Packet byte |
| s_valid | input | 1 | Byte source has a byte |
| s_last | input | 1 | Byte is the last of its packet |
| s_ready | output | 1 | Transmitter takes the byte on this edge |
| fcs_inhibit | input | 1 | Leave out the check sequence for this frame |
| abort_req | input | 1 | Pulse to abort the frame in progress |
| tx_bit | output | 1 | Serial line output |
| eop | output | 1 | Pulse: closing flag completed |
| underflow | output | 1 | Pulse: source ran dry mid-frame |

## Verification
The hardest situations to reach from the ports are an abort that lands partway through a byte, and a run of five 1s that ends exactly where the data meets the check sequence or where the check sequence meets the closing flag. The stimulus withholds bytes, or pulses the abort command, only after a chosen number of handshakes. It also sends packets full of 0xFF and flag-like bytes under two different enable rates. A bench-side deframer removes inserted zeros, finds flags and aborts, and checks each frame against the queued expectation using the CRC residue.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned FCS_W  = 16;

  localparam logic [BYTE_W-1:0] FLAG_PAT  = 8'h7E;
  localparam logic [BYTE_W-1:0] ABORT_PAT = 8'hFE;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_FCS,
    ST_CLOSE,
    ST_ABORT
  } tx_state_e;

  // Reflected CRC update over one byte, low bit first.
  function automatic logic [FCS_W-1:0] crc_step(input logic [FCS_W-1:0] c,
                                                input logic [BYTE_W-1:0] d,
                                                input logic [FCS_W-1:0] poly);
    logic [FCS_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ poly;
    end
    return r;
  endfunction

endpackage

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc
  import hdlc_tx_pkg::*;
#(
  parameter logic [FCS_W-1:0] POLY   = 16'h8408,
  parameter logic [FCS_W-1:0] PRESET = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              upd,
  input  logic [BYTE_W-1:0] din,
  output logic [FCS_W-1:0]  crc
);

  always_ff @(posedge clk) begin
    if (!rst_n) crc <= PRESET;
    else if (upd) crc <= crc_step(init ? PRESET : crc, din, POLY);
  end

endmodule

// File: rtl/hdlc_tx_shifter.sv
module hdlc_tx_shifter #(
  parameter int unsigned SYM_W   = 16,
  parameter int unsigned RUN_LEN = 5,
  parameter logic [SYM_W-1:0] RST_SYM = 16'h007E,
  parameter int unsigned RST_LEN = 8,
  localparam int unsigned LEN_W = $clog2(SYM_W + 1),
  localparam int unsigned RUN_W = $clog2(RUN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             cut,
  input  logic [SYM_W-1:0] ld_sym,
  input  logic [LEN_W-1:0] ld_len,
  input  logic             ld_stuff,
  output logic             sym_end,
  output logic             tx_bit
);

  logic [SYM_W-1:0] sh;
  logic [LEN_W-1:0] cnt;
  logic             stuff_cur;
  logic [RUN_W-1:0] ones;
  logic             stuff_now;

  assign stuff_now = (ones == RUN_W'(RUN_LEN));
  assign sym_end   = bit_en && !stuff_now && (cnt == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh        <= RST_SYM;
      cnt       <= LEN_W'(RST_LEN);
      stuff_cur <= 1'b0;
      ones      <= '0;
      tx_bit    <= 1'b1;
    end else if (bit_en) begin
      if (cut) begin
        tx_bit    <= ld_sym[0];
        sh        <= ld_sym >> 1;
        cnt       <= ld_len - 1'b1;
        stuff_cur <= ld_stuff;
        ones      <= (ld_stuff && ld_sym[0]) ? RUN_W'(1) : '0;
      end else if (stuff_now) begin
        tx_bit <= 1'b0;
        ones   <= '0;
      end else begin
        tx_bit <= sh[0];
        ones   <= (stuff_cur && sh[0]) ? ones + 1'b1 : '0;
        if (cnt == LEN_W'(1)) begin
          sh        <= ld_sym;
          cnt       <= ld_len;
          stuff_cur <= ld_stuff;
        end else begin
          sh  <= sh >> 1;
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R4: a full run of ones is always followed by a zero on the line
  p_stuff_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && stuff_now && !cut) |=> !tx_bit);

  // R11: the line only moves on enabled cycles
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));

  // R2: a symbol always has bits left to send
  p_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0);

endmodule

// File: rtl/hdlc_tx.sv
module hdlc_tx
  import hdlc_tx_pkg::*;
#(
  parameter int unsigned       RUN_LEN    = 5,
  parameter logic [FCS_W-1:0]  CRC_POLY   = 16'h8408,
  parameter logic [FCS_W-1:0]  CRC_PRESET = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  input  logic              fcs_inhibit,
  input  logic              abort_req,
  output logic              tx_bit,
  output logic              eop,
  output logic              underflow
);

  localparam int unsigned SYM_W = FCS_W;
  localparam int unsigned LEN_W = $clog2(SYM_W + 1);
  localparam logic [SYM_W-1:0] FLAG_SYM  = SYM_W'(FLAG_PAT);
  localparam logic [SYM_W-1:0] ABORT_SYM = SYM_W'(ABORT_PAT);

  tx_state_e        state, nxt_state;
  logic             last_seen, first_byte, inh_q, abort_pend;
  logic             eop_q, uf_q;
  logic             sym_end, in_frame, do_cut, can_take, accept;
  logic [SYM_W-1:0] nxt_sym;
  logic [LEN_W-1:0] nxt_len;
  logic             nxt_stuff, crc_init, crc_upd, uf_set, eop_set;
  logic [FCS_W-1:0] crc_val;

  assign in_frame  = (state == ST_DATA) || (state == ST_FCS);
  assign do_cut    = bit_en && abort_pend && in_frame;
  assign can_take  = (state == ST_IDLE) || ((state == ST_DATA) && !last_seen);
  assign s_ready   = sym_end && can_take && !do_cut;
  assign accept    = s_ready && s_valid;
  assign eop       = eop_q;
  assign underflow = uf_q;

  always_comb begin
    nxt_sym   = FLAG_SYM;
    nxt_len   = LEN_W'(BYTE_W);
    nxt_stuff = 1'b0;
    nxt_state = state;
    crc_init  = 1'b0;
    crc_upd   = 1'b0;
    uf_set    = 1'b0;
    eop_set   = 1'b0;
    if (do_cut) begin
      nxt_sym   = ABORT_SYM;
      nxt_state = ST_ABORT;
    end else if (sym_end) begin
      unique case (state)
        ST_IDLE: if (s_valid) begin
          nxt_sym   = SYM_W'(s_data);
          nxt_stuff = 1'b1;
          nxt_state = ST_DATA;
          crc_init  = 1'b1;
          crc_upd   = 1'b1;
        end
        ST_DATA: begin
          if (last_seen) begin
            if (first_byte) begin
              nxt_sym   = ABORT_SYM;
              nxt_state = ST_ABORT;
            end else if (inh_q) begin
              nxt_state = ST_CLOSE;
            end else begin
              nxt_sym   = ~crc_val;
              nxt_len   = LEN_W'(FCS_W);
              nxt_stuff = 1'b1;
              nxt_state = ST_FCS;
            end
          end else if (s_valid) begin
            nxt_sym   = SYM_W'(s_data);
            nxt_stuff = 1'b1;
            crc_upd   = 1'b1;
          end else begin
            nxt_sym   = ABORT_SYM;
            nxt_state = ST_ABORT;
            uf_set    = 1'b1;
          end
        end
        ST_FCS:   nxt_state = ST_CLOSE;
        ST_CLOSE: begin
          nxt_state = ST_IDLE;
          eop_set   = 1'b1;
        end
        default:  nxt_state = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      last_seen  <= 1'b0;
      first_byte <= 1'b0;
      inh_q      <= 1'b0;
      abort_pend <= 1'b0;
      eop_q      <= 1'b0;
      uf_q       <= 1'b0;
    end else begin
      state <= nxt_state;
      eop_q <= eop_set;
      uf_q  <= uf_set;
      if (accept) begin
        last_seen  <= s_last;
        first_byte <= (state == ST_IDLE);
        if (state == ST_IDLE) inh_q <= fcs_inhibit;
      end
      if (do_cut || !in_frame) abort_pend <= 1'b0;
      else if (abort_req)      abort_pend <= 1'b1;
    end
  end

  hdlc_tx_crc #(.POLY(CRC_POLY), .PRESET(CRC_PRESET)) u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .init (crc_init),
    .upd  (crc_upd),
    .din  (s_data),
    .crc  (crc_val)
  );

  hdlc_tx_shifter #(
    .SYM_W  (SYM_W),
    .RUN_LEN(RUN_LEN),
    .RST_SYM(FLAG_SYM),
    .RST_LEN(BYTE_W)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .cut     (do_cut),
    .ld_sym  (nxt_sym),
    .ld_len  (nxt_len),
    .ld_stuff(nxt_stuff),
    .sym_end (sym_end),
    .tx_bit  (tx_bit)
  );

  // R3: an accepted byte always leaves the transmitter sending data
  p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && s_valid) |=> (state == ST_DATA));

  // R7: completion and underflow never coincide
  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eop, underflow}));

  // R8: an underflow pulse always comes with the abort pattern
  p_uf_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (state == ST_ABORT));

  // R9: a pending abort starts with a zero on the next enabled bit
  p_abort_cut_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && abort_pend && in_frame) |=> (state == ST_ABORT && !tx_bit));

  // R10: a one-byte packet ends in an abort without underflow
  p_short_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_end && state == ST_DATA && last_seen && first_byte && !abort_pend)
      |=> (state == ST_ABORT && !underflow));

endmodule

// File: tb/hdlc_tx_bench.sv
module hdlc_tx_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic       s_valid = 1'b0;
  logic       s_last = 1'b0;
  logic       s_ready;
  logic       fcs_inhibit = 1'b0;
  logic       abort_req = 1'b0;
  logic       tx_bit;
  logic       eop;
  logic       underflow;

  hdlc_tx u_hdlc_tx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .fcs_inhibit(fcs_inhibit), .abort_req(abort_req),
    .tx_bit(tx_bit), .eop(eop), .underflow(underflow)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // scoreboard: kind 0 = frame with FCS, 2 = frame without, 1 = abort
  int         kind_q[$];
  int         len_q[$];
  string      tag_q[$];
  logic [7:0] byte_q[$];
  logic [7:0] fr [0:15];

  int en_div = 3;
  int ph = 0;
  bit en_was = 0;

  int   ones = 0, nbits = 0;
  bit   hunt = 1;
  logic bitbuf [0:255];
  int   eop_cnt = 0, uf_cnt = 0, stuff_cnt = 0, flag_cnt = 0, hold_err = 0;
  logic prev_bit = 1'b1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bit enable generator, changes just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      en_was = bit_en;
      ph++;
      bit_en = rst_n && ((ph % en_div) == 0);
    end
  end

  task automatic frame_event(input int nb);
    int k, l, exp_nb;
    logic [7:0] got, e;
    logic [15:0] c;
    logic fb;
    string t;
    if (kind_q.size() == 0) begin
      check(0, "R2", "unexpected frame", nb, 0);
      return;
    end
    k = kind_q.pop_front(); l = len_q.pop_front(); t = tag_q.pop_front();
    if (k == 1) begin
      check(0, t, "complete frame where abort expected", nb, 0);
      for (int j = 0; j < l; j++) void'(byte_q.pop_front());
      return;
    end
    exp_nb = (k == 0) ? 8 * (l + 2) : 8 * l;
    check(nb == exp_nb, t, "frame bit count", nb, exp_nb);
    for (int j = 0; j < l; j++) begin
      e = byte_q.pop_front();
      got = 8'h00;
      for (int i = 0; i < 8; i++)
        if (8 * j + i < nb) got[i] = bitbuf[8 * j + i];
      check(got == e, "R3", "data byte", got, e);
    end
    if (k == 0) begin
      c = 16'hFFFF;
      for (int i = 0; i < nb; i++) begin
        fb = c[0] ^ bitbuf[i];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
      check(c == 16'hF0B8, "R5", "FCS residue", c, 16'hF0B8);
    end
    check(eop == 1'b1, "R7", "eop with last closing flag bit", eop, 1);
  endtask

  task automatic abort_event();
    int k, l;
    string t;
    if (kind_q.size() == 0) begin
      check(0, "R9", "unexpected abort", 1, 0);
      return;
    end
    k = kind_q.pop_front(); l = len_q.pop_front(); t = tag_q.pop_front();
    for (int j = 0; j < l; j++) void'(byte_q.pop_front());
    check(k == 1, t, "abort where frame expected", 1, 0);
  endtask

  // monitor: deframes the serial line
  always @(negedge clk) begin
    if (!rst_n) begin
      ones = 0; nbits = 0; hunt = 1;
    end else begin
      if (!en_was && tx_bit !== prev_bit) hold_err++;
      if (en_was) begin
        if (tx_bit) begin
          ones++;
          if (ones == 7) begin
            if (!hunt) abort_event();
            hunt = 1; nbits = 0;
          end else if (ones < 7) begin
            if (nbits < 256) bitbuf[nbits] = 1'b1;
            nbits++;
          end
        end else begin
          if (ones == 5) stuff_cnt++;
          else if (ones == 6) begin
            flag_cnt++;
            if (!hunt && nbits - 7 > 0) frame_event(nbits - 7);
            nbits = 0; hunt = 0;
          end else if (ones < 7) begin
            if (nbits < 256) bitbuf[nbits] = 1'b0;
            nbits++;
          end
          ones = 0;
        end
      end
      prev_bit = tx_bit;
      if (eop) eop_cnt++;
      if (underflow) uf_cnt++;
    end
  end

  // driver: queues the expectation, then offers bytes
  task automatic send_frame(input int n, input bit inh, input int stop_after,
                            input bit do_abort, input string tag);
    int cnt;
    if (stop_after >= 0 || n == 1) begin
      kind_q.push_back(1); len_q.push_back(0); tag_q.push_back(tag);
    end else begin
      kind_q.push_back(inh ? 2 : 0); len_q.push_back(n); tag_q.push_back(tag);
      for (int j = 0; j < n; j++) byte_q.push_back(fr[j]);
    end
    cnt = (stop_after >= 0) ? stop_after : n;
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = fr[i]; s_last = (i == n - 1); fcs_inhibit = inh;
      while (!s_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
    if (do_abort) begin
      abort_req = 1'b1;
      @(negedge clk);
      abort_req = 1'b0;
    end
  endtask

  task automatic wait_idle();
    while (kind_q.size() != 0) @(negedge clk);
    repeat (60) @(negedge clk);
    fcs_inhibit = 1'b0;
  endtask

  initial begin
    int s0, e0, u0;
    repeat (4) @(negedge clk);
    check(tx_bit == 1'b1, "R1", "tx_bit in reset", tx_bit, 1);
    check(s_ready == 1'b0, "R1", "s_ready in reset", s_ready, 0);
    check(eop == 1'b0 && underflow == 1'b0, "R1", "status in reset", {eop, underflow}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_bit == 1'b1, "R1", "tx_bit after reset", tx_bit, 1);
    repeat (60) @(negedge clk);
    check(flag_cnt >= 1, "R2", "idle flags seen", flag_cnt, 1);

    // R9: abort while idle is ignored; plain frame follows
    abort_req = 1'b1; @(negedge clk); abort_req = 1'b0;
    fr[0] = 8'hA5; fr[1] = 8'h01; fr[2] = 8'hFF;
    send_frame(3, 0, -1, 0, "R9");
    wait_idle();

    // R4: runs of ones in data
    s0 = stuff_cnt;
    fr[0] = 8'hFF; fr[1] = 8'hFF; fr[2] = 8'h7E; fr[3] = 8'h3F; fr[4] = 8'hF8;
    send_frame(5, 0, -1, 0, "R4");
    wait_idle();
    check(stuff_cnt - s0 >= 4, "R4", "inserted zeros", stuff_cnt - s0, 4);

    // R6: no FCS, data ending in ones before the closing flag
    fr[0] = 8'hF8; fr[1] = 8'h1F;
    send_frame(2, 1, -1, 0, "R6");
    wait_idle();

    // R10: one-byte packet
    e0 = eop_cnt; u0 = uf_cnt;
    fr[0] = 8'h55;
    send_frame(1, 0, -1, 0, "R10");
    wait_idle();
    check(eop_cnt == e0, "R10", "no eop for short packet", eop_cnt - e0, 0);
    check(uf_cnt == u0, "R10", "no underflow for short packet", uf_cnt - u0, 0);

    // R8: source runs dry after two bytes
    fr[0] = 8'h12; fr[1] = 8'h34; fr[2] = 8'h56; fr[3] = 8'h78;
    send_frame(4, 0, 2, 0, "R8");
    wait_idle();
    check(uf_cnt == u0 + 1, "R8", "underflow pulses", uf_cnt - u0, 1);

    // R9: abort command after three bytes
    for (int i = 0; i < 6; i++) fr[i] = 8'(8'h3C + i);
    send_frame(6, 0, 3, 1, "R9");
    wait_idle();

    // R3: full-rate line, longer packet
    en_div = 1;
    for (int i = 0; i < 8; i++) fr[i] = 8'(i * 37 + 11);
    send_frame(8, 0, -1, 0, "R3");
    wait_idle();

    check(eop_cnt == 4, "R7", "eop count", eop_cnt, 4);
    check(uf_cnt == 1, "R8", "underflow total", uf_cnt, 1);
    check(hold_err == 0, "R11", "line moved without enable", hold_err, 0);
    check(kind_q.size() == 0, "R2", "unmatched expectations", kind_q.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule